// File: doc/BRIEF.md
# Memory-Mapped Timer Compare Unit

This block keeps a free-running 64-bit time counter and, for each of several hardware threads, a 64-bit compare value. Each thread has its own level interrupt line. The line is high in every cycle in which the time counter is greater than or equal to that thread's compare value.

Software reaches the block through a 32-bit register port with an address, write data, a write strobe and a combinational read-data return. A 64-bit compare value therefore takes two separate 32-bit writes. A write to one half never disturbs the other half. Between the two writes the interrupt logic compares against the mixed value that is currently stored.

Compare slots are 8 bytes each and sit back to back from address 0, so the thread index is the address divided by 8. The time counter appears as two read-only halves at its own base address.

Every access is first sorted into one of five access classes, and that class drives both the write enables and the read selection:
- ACC_CMP_LO: compare low half.
- ACC_CMP_HI: compare high half.
- ACC_TIME_LO: time low half.
- ACC_TIME_HI: time high half.
- ACC_INVALID: anything else.

The block has no sequential control states. The classification is redone from the address in every cycle, so there are no transitions to name.

Top module: `timer_compare_unit`

## Requirements
- R1: After reset every compare register holds all ones, the time counter holds zero and every interrupt line is low.
- R2: A write to byte offset 0 of a thread's slot (address = 8*thread) replaces compare bits 31:0 with the write data and leaves bits 63:32 unchanged.
- R3: A write to byte offset 4 of a thread's slot (address = 8*thread + 4) replaces compare bits 63:32 with the write data and leaves bits 31:0 unchanged.
- R4: A write whose slot index (address / 8) is NUM_HARTS or larger, within the compare region, changes no state.
- R5: A write to a compare slot at a byte offset other than 0 or 4 changes no state.
- R6: Interrupt line i is high exactly when the time counter is greater than or equal to compare register i. This holds in every cycle, including while a register holds a mixed value between its two half writes.
- R7: The time counter advances by one on each clock edge where tick_en is high and holds otherwise.
- R8: The time counter reads at TIME_BASE (bits 31:0) and TIME_BASE+4 (bits 63:32). Writes to those addresses are ignored.
- R9: read_data shows the addressed half in the same cycle. Any address outside the valid classes reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Advances the time counter by one when high |
| reg_addr | input | ADDR_W | Byte address of the access |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe, one write per cycle it is high |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| timer_irq | output | NUM_HARTS | Level interrupt per thread |

## Verification
A compare half that was written with the wrong merge shows up at once on reg_rdata when that half is read back. It also shows on timer_irq in the very cycle after the write edge, because the comparison is combinational on the stored values. The bench therefore interleaves half writes with readbacks of both halves. It also places compare values so that a mixed register sits just above or at the time value, which makes a corrupted half flip an interrupt line. Writes to out-of-range slots, bad offsets and the time halves are followed by readbacks of every register they could have hit.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

    typedef enum logic [2:0] {
        ACC_INVALID = 3'd0,
        ACC_CMP_LO  = 3'd1,
        ACC_CMP_HI  = 3'd2,
        ACC_TIME_LO = 3'd3,
        ACC_TIME_HI = 3'd4
    } tcu_acc_e;

    localparam int unsigned SLOT_BYTES = 8;
    localparam int unsigned HALF_W     = 32;
    localparam int unsigned FULL_W     = 64;

endpackage

// File: rtl/tcu_addr_decode.sv
module tcu_addr_decode
    import tcu_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 4,
    parameter int unsigned ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] TIME_BASE = 16'h0800
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     addr,
    input  logic                  wr,
    output tcu_acc_e              acc_kind,
    output logic [HART_W-1:0]     hart_idx,
    output logic [NUM_HARTS-1:0]  wr_lo_sel,
    output logic [NUM_HARTS-1:0]  wr_hi_sel
);
    localparam int unsigned HART_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;
    localparam logic [ADDR_W-1:0] CMP_SPAN     = ADDR_W'(NUM_HARTS * SLOT_BYTES);
    localparam logic [ADDR_W-1:0] TIME_HI_ADDR = TIME_BASE + ADDR_W'(4);

    logic in_cmp;
    logic in_time_lo;
    logic in_time_hi;

    assign in_cmp     = (addr < CMP_SPAN);
    assign in_time_lo = (addr == TIME_BASE);
    assign in_time_hi = (addr == TIME_HI_ADDR);
    assign hart_idx   = addr[3 +: HART_W];

    // classification of the access
    always_comb begin
        acc_kind = ACC_INVALID;
        if (in_cmp) begin
            unique case (addr[2:0])
                3'd0:    acc_kind = ACC_CMP_LO;
                3'd4:    acc_kind = ACC_CMP_HI;
                default: acc_kind = ACC_INVALID;
            endcase
        end else if (in_time_lo) begin
            acc_kind = ACC_TIME_LO;
        end else if (in_time_hi) begin
            acc_kind = ACC_TIME_HI;
        end
    end

    // per-thread write enables
    always_comb begin
        wr_lo_sel = '0;
        wr_hi_sel = '0;
        if (wr) begin
            unique case (acc_kind)
                ACC_CMP_LO: wr_lo_sel[hart_idx] = 1'b1;
                ACC_CMP_HI: wr_hi_sel[hart_idx] = 1'b1;
                ACC_TIME_LO, ACC_TIME_HI, ACC_INVALID: ;
                default: ;
            endcase
        end
    end

    // R5: at most one half of one thread is selected per write
    a_r5_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_lo_sel, wr_hi_sel}));

    // R5: an odd offset never selects a compare half
    a_r5_bad_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr[1:0] != 2'b00) |-> ((wr_lo_sel == '0) && (wr_hi_sel == '0)));

    // R4: addresses past the implemented slots never select
    a_r4_range: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !in_cmp) |-> ((wr_lo_sel == '0) && (wr_hi_sel == '0)));

endmodule

// File: rtl/tcu_time_base.sv
module tcu_time_base
    import tcu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    output logic [FULL_W-1:0] time_q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            time_q <= '0;
        end else if (tick_en) begin
            time_q <= time_q + FULL_W'(1);
        end
    end

    // R7: one step per enabled tick
    a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick_en |=> (time_q == $past(time_q) + FULL_W'(1)));

    // R7: held without tick
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_en |=> $stable(time_q));

endmodule

// File: rtl/tcu_cmp_bank.sv
module tcu_cmp_bank
    import tcu_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_HARTS-1:0]               wr_lo_sel,
    input  logic [NUM_HARTS-1:0]               wr_hi_sel,
    input  logic [HALF_W-1:0]                  wdata,
    input  logic [FULL_W-1:0]                  time_q,
    output logic [NUM_HARTS-1:0][FULL_W-1:0]   cmp_q,
    output logic [NUM_HARTS-1:0]               irq
);

    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
        // each half has its own enable; the other half is never rewritten
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_q[h] <= '1;
            end else begin
                if (wr_lo_sel[h]) cmp_q[h][HALF_W-1:0]      <= wdata;
                if (wr_hi_sel[h]) cmp_q[h][FULL_W-1:HALF_W] <= wdata;
            end
        end

        assign irq[h] = (time_q >= cmp_q[h]);

        // R2: low write keeps the high half
        a_r2_lo_keeps_hi: assert property (@(posedge clk) disable iff (!rst_n)
            wr_lo_sel[h] |=> ((cmp_q[h][FULL_W-1:HALF_W] == $past(cmp_q[h][FULL_W-1:HALF_W]))
                              && (cmp_q[h][HALF_W-1:0] == $past(wdata))));

        // R3: high write keeps the low half
        a_r3_hi_keeps_lo: assert property (@(posedge clk) disable iff (!rst_n)
            wr_hi_sel[h] |=> ((cmp_q[h][HALF_W-1:0] == $past(cmp_q[h][HALF_W-1:0]))
                              && (cmp_q[h][FULL_W-1:HALF_W] == $past(wdata))));

        // R4: no select, no change
        a_r4_unselected_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_lo_sel[h] || wr_hi_sel[h]) |=> $stable(cmp_q[h]));
    end

endmodule

// File: rtl/timer_compare_unit.sv
module timer_compare_unit
    import tcu_pkg::*;
#(
    parameter int unsigned NUM_HARTS = 4,
    parameter int unsigned ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] TIME_BASE = 16'h0800
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick_en,
    input  logic [ADDR_W-1:0]     reg_addr,
    input  logic [31:0]           reg_wdata,
    input  logic                  reg_wr,
    output logic [31:0]           reg_rdata,
    output logic [NUM_HARTS-1:0]  timer_irq
);
    localparam int unsigned HART_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

    tcu_acc_e                       acc_kind;
    logic [HART_W-1:0]              hart_idx;
    logic [NUM_HARTS-1:0]           wr_lo_sel;
    logic [NUM_HARTS-1:0]           wr_hi_sel;
    logic [FULL_W-1:0]              time_q;
    logic [NUM_HARTS-1:0][FULL_W-1:0] cmp_q;

    tcu_addr_decode #(
        .NUM_HARTS (NUM_HARTS),
        .ADDR_W    (ADDR_W),
        .TIME_BASE (TIME_BASE)
    ) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (reg_addr),
        .wr        (reg_wr),
        .acc_kind  (acc_kind),
        .hart_idx  (hart_idx),
        .wr_lo_sel (wr_lo_sel),
        .wr_hi_sel (wr_hi_sel)
    );

    tcu_time_base u_time (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .time_q  (time_q)
    );

    tcu_cmp_bank #(
        .NUM_HARTS (NUM_HARTS)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_lo_sel (wr_lo_sel),
        .wr_hi_sel (wr_hi_sel),
        .wdata     (reg_wdata),
        .time_q    (time_q),
        .cmp_q     (cmp_q),
        .irq       (timer_irq)
    );

    // read return, selected by access class
    always_comb begin
        unique case (acc_kind)
            ACC_CMP_LO:  reg_rdata = cmp_q[hart_idx][HALF_W-1:0];
            ACC_CMP_HI:  reg_rdata = cmp_q[hart_idx][FULL_W-1:HALF_W];
            ACC_TIME_LO: reg_rdata = time_q[HALF_W-1:0];
            ACC_TIME_HI: reg_rdata = time_q[FULL_W-1:HALF_W];
            ACC_INVALID: reg_rdata = '0;
            default:     reg_rdata = '0;
        endcase
    end

    // R6: without a write, a raised line stays raised as time only grows
    for (genvar h = 0; h < NUM_HARTS; h++) begin : g_chk
        a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (timer_irq[h] && !reg_wr) |=> timer_irq[h]);
    end

    // R8: time halves never move a compare register
    a_r8_time_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (acc_kind == ACC_TIME_LO || acc_kind == ACC_TIME_HI)) |=> $stable(cmp_q));

endmodule

// File: tb/sim_timer_compare_unit.sv
`timescale 1ns/1ps
module sim_timer_compare_unit;

    localparam int unsigned NH = 4;
    localparam logic [15:0] TB = 16'h0800;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_rdata;
    logic [NH-1:0] timer_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    bit          irq_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    timer_compare_unit #(.NUM_HARTS(NH), .ADDR_W(16), .TIME_BASE(TB)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr),
        .reg_rdata(reg_rdata), .timer_irq(timer_irq)
    );

    // monitor: compare one queued item per falling edge
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [31:0] e;
            logic [31:0] a;
            bit is_irq;
            string t;
            e = exp_q.pop_front();
            is_irq = irq_q.pop_front();
            t = tag_q.pop_front();
            a = is_irq ? {{(32-NH){1'b0}}, timer_irq} : reg_rdata;
            checks++;
            if (a !== e) begin
                errors++;
                $display("FAIL %s %s actual=%h expected=%h", t, is_irq ? "irq" : "rdata", a, e);
            end
        end
    end

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #2;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [31:0] e, input string t);
        @(posedge clk); #2;
        reg_addr = a;
        exp_q.push_back(e); irq_q.push_back(1'b0); tag_q.push_back(t);
    endtask

    task automatic chk_irq(input logic [NH-1:0] e, input string t);
        @(posedge clk); #2;
        exp_q.push_back({{(32-NH){1'b0}}, e}); irq_q.push_back(1'b1); tag_q.push_back(t);
    endtask

    task automatic ticks(input int n);
        @(posedge clk); #2;
        tick_en = 1'b1;
        repeat (n) @(posedge clk);
        #2 tick_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        rd(16'h0000, 32'hFFFF_FFFF, "R1");
        rd(16'h001C, 32'hFFFF_FFFF, "R1");
        rd(TB,       32'h0,         "R1");
        chk_irq(4'b0000, "R1");

        // R2 low half write
        wr(16'h0008, 32'h1234_5678);
        rd(16'h0008, 32'h1234_5678, "R2");
        rd(16'h000C, 32'hFFFF_FFFF, "R2");

        // R3 high half write, then low again keeps high
        wr(16'h000C, 32'h0000_00AB);
        rd(16'h000C, 32'h0000_00AB, "R3");
        rd(16'h0008, 32'h1234_5678, "R3");
        wr(16'h0008, 32'h0000_0009);
        rd(16'h000C, 32'h0000_00AB, "R2");
        rd(16'h0008, 32'h0000_0009, "R2");

        // R4 slot past the implemented threads
        wr(16'h0020, 32'h0);
        wr(16'h0024, 32'h0);
        rd(16'h0000, 32'hFFFF_FFFF, "R4");
        rd(16'h0018, 32'hFFFF_FFFF, "R4");
        rd(16'h001C, 32'hFFFF_FFFF, "R4");
        rd(16'h0020, 32'h0,         "R9");
        chk_irq(4'b0000, "R4");

        // R5 bad offset inside a slot
        wr(16'h0002, 32'h0);
        wr(16'h0006, 32'h0);
        rd(16'h0000, 32'hFFFF_FFFF, "R5");
        rd(16'h0004, 32'hFFFF_FFFF, "R5");
        rd(16'h0002, 32'h0,         "R9");

        // R6 interrupt from full and mixed values
        wr(16'h0010, 32'h0);
        chk_irq(4'b0000, "R6");
        wr(16'h0014, 32'h0);
        chk_irq(4'b0100, "R6");
        wr(16'h0004, 32'h0);
        chk_irq(4'b0100, "R6");

        // R7 tick and hold
        ticks(5);
        rd(TB, 32'd5, "R7");
        repeat (3) @(posedge clk);
        rd(TB, 32'd5, "R7");

        // R8 time writes ignored, high half readable
        wr(TB, 32'h0000_0100);
        wr(TB + 16'h4, 32'h0000_0001);
        rd(TB,          32'd5, "R8");
        rd(TB + 16'h4,  32'h0, "R8");
        rd(16'h0008,    32'h0000_0009, "R8");

        // R6 mixed value during a two-step update of thread 3
        wr(16'h001C, 32'h0);
        chk_irq(4'b0100, "R6");
        wr(16'h0018, 32'd5);
        chk_irq(4'b1100, "R6");
        wr(16'h0018, 32'd6);
        chk_irq(4'b0100, "R6");

        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule